// File: doc/BRIEF.md
# Floppy Drive Interface Glue

This block is the glue logic between a floppy disk controller chip and two drive connectors, one for large-format drives and one for mini drives. The CPU writes a control byte to I/O port 0x34. That byte holds the drive selection, the connector type, the side and a head-settle preset. Reading the same port returns a status byte built from the controller's request, interrupt and head-load lines, together with a head-settled flag that the block produces itself.

A drive-select line reaches a drive only while the controller asserts head-load. The controller's short step pulse is widened by a retriggerable timer to a fixed number of system clock cycles. The default of 64 cycles gives about 16 µs at 4 MHz. Only the connector chosen by the type bit receives the select, step and side signals. While the mini type is chosen, the ready and separate-clock inputs that return to the controller are forced high, because a mini drive does not provide them.

Top module: `floppy_glue`

## Requirements
- R1: After reset the control byte is zero: every select, step and side output is low, and read data is zero.
- R2: A write to port PORT_ADDR (0x34) is stored in the control byte and takes effect on the cycle after the write edge. A write to any other address leaves every output unchanged.
- R3: Each select output is the matching bit of control[3:0] ANDed with fdcHld. Select outputs are active high, and bit n drives drive n.
- R4: Control bit 4 chooses the connector: 0 routes to the large-format (maxi) connector, 1 routes to the mini connector. The connector that is not chosen has every select, step and side output held low.
- R5: A rising edge on fdcStep drives the chosen connector's step output high for exactly STEP_CYCLES consecutive cycles, starting on the cycle after the edge is sampled.
- R6: A new rising edge on fdcStep while the step output is high restarts the count, so the output stays high for STEP_CYCLES cycles after the new edge.
- R7: While control bit 4 is 1, fdcReady and fdcSepClk are 1. While bit 4 is 0, they follow driveReady and driveSepClk.
- R8: When ioRdEn is high and ioAddr equals 0x34, read data is {fdcDrq, fdcIntrq, fdcHld, 4'b0, settled}, with bit 7 = DRQ, bit 6 = INTRQ, bit 5 = HLD and bit 0 = settled. In every other case, read data is zero.
- R9: The settled flag becomes 1 after fdcHld has been sampled high on (control[7:6]+1)*SETTLE_UNIT consecutive edges. It is 0 while fdcHld is low.
- R10: Control bit 5 is the side select and appears on the chosen connector's side output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 8 | CPU I/O port address |
| ioWrData | input | 8 | CPU write data |
| ioWrEn | input | 1 | I/O write strobe |
| ioRdEn | input | 1 | I/O read strobe |
| ioRdData | output | 8 | Status read data |
| fdcStep | input | 1 | Controller step pulse |
| fdcHld | input | 1 | Controller head-load |
| fdcDrq | input | 1 | Controller data request |
| fdcIntrq | input | 1 | Controller end-of-job interrupt |
| driveReady | input | 1 | Ready line from the drives |
| driveSepClk | input | 1 | Separate clock line from the drives |
| fdcReady | output | 1 | Ready line to the controller |
| fdcSepClk | output | 1 | Separate clock line to the controller |
| maxiSel | output | 4 | Large-format drive selects |
| maxiStep | output | 1 | Large-format step |
| maxiSide | output | 1 | Large-format side select |
| miniSel | output | 4 | Mini drive selects |
| miniStep | output | 1 | Mini step |
| miniSide | output | 1 | Mini side select |

## Verification
The select, side, ready, separate-clock and read-data outputs are combinational from the inputs and the control byte. The bench drives inputs on the falling edge and checks these outputs on the next falling edge. A control write is checked on the falling edge after the rising edge that stores it. Step widths are measured by sampling the step output on every falling edge after the edge is taken and counting the high samples, so each sample lines up with one step-counter register update. The settled flag is compared on every falling edge against the number of rising edges seen since fdcHld went high, which matches a counter with one register stage.

// File: rtl/floppy_glue_pkg.sv
package floppy_glue_pkg;
  localparam int CtlSelLsb  = 0;
  localparam int CtlMiniBit = 4;
  localparam int CtlSideBit = 5;
  localparam int CtlPreLsb  = 6;

  typedef struct packed {
    logic regWr;
    logic rdSel;
    logic stepOn;
    logic headSettled;
  } glueStrobe_t;
endpackage

// File: rtl/floppy_glue_ctrl.sv
module floppy_glue_ctrl
  import floppy_glue_pkg::*;
#(
  parameter logic [7:0] PORT_ADDR   = 8'h34,
  parameter int         STEP_CYCLES = 64,
  parameter int         SETTLE_UNIT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  ioAddr,
  input  logic        ioWrEn,
  input  logic        ioRdEn,
  input  logic        fdcStep,
  input  logic        fdcHld,
  input  logic [1:0]  settlePreset,
  output glueStrobe_t strobe
);
  localparam int StepW   = $clog2(STEP_CYCLES + 1);
  localparam int SettleW = $clog2(4 * SETTLE_UNIT + 1);

  logic               stepPrev;
  logic [StepW-1:0]   stepCnt;
  logic [SettleW-1:0] settleCnt;
  logic [SettleW-1:0] settleTarget;
  logic               stepEdge;
  logic               addrHit;

  assign addrHit      = (ioAddr == PORT_ADDR);
  assign stepEdge     = fdcStep & ~stepPrev;
  assign settleTarget = SettleW'((32'(settlePreset) + 1) * SETTLE_UNIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepPrev <= 1'b0;
      stepCnt  <= '0;
    end else begin
      stepPrev <= fdcStep;
      if (stepEdge)
        stepCnt <= StepW'(STEP_CYCLES);
      else if (stepCnt != '0)
        stepCnt <= stepCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !fdcHld)
      settleCnt <= '0;
    else if (settleCnt < settleTarget)
      settleCnt <= settleCnt + 1'b1;
  end

  always_comb begin
    strobe.regWr       = ioWrEn & addrHit;
    strobe.rdSel       = ioRdEn & addrHit;
    strobe.stepOn      = (stepCnt != '0);
    strobe.headSettled = fdcHld & (settleCnt >= settleTarget);
  end
endmodule

// File: rtl/floppy_glue_datapath.sv
module floppy_glue_datapath
  import floppy_glue_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  glueStrobe_t           strobe,
  input  logic [7:0]            ioWrData,
  input  logic                  fdcHld,
  input  logic                  fdcDrq,
  input  logic                  fdcIntrq,
  input  logic                  driveReady,
  input  logic                  driveSepClk,
  output logic [1:0]            settlePreset,
  output logic [7:0]            ioRdData,
  output logic                  fdcReady,
  output logic                  fdcSepClk,
  output logic [NUM_DRIVES-1:0] maxiSel,
  output logic                  maxiStep,
  output logic                  maxiSide,
  output logic [NUM_DRIVES-1:0] miniSel,
  output logic                  miniStep,
  output logic                  miniSide
);
  logic [7:0]            ctlReg;
  logic                  useMini;
  logic [NUM_DRIVES-1:0] qualSel;

  always_ff @(posedge clk) begin
    if (!rstN)
      ctlReg <= '0;
    else if (strobe.regWr)
      ctlReg <= ioWrData;
  end

  assign useMini      = ctlReg[CtlMiniBit];
  assign settlePreset = ctlReg[CtlPreLsb +: 2];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_sel
    assign qualSel[d] = ctlReg[CtlSelLsb + d] & fdcHld;
    assign maxiSel[d] = qualSel[d] & ~useMini;
    assign miniSel[d] = qualSel[d] & useMini;
  end

  assign maxiStep  = strobe.stepOn & ~useMini;
  assign miniStep  = strobe.stepOn & useMini;
  assign maxiSide  = ctlReg[CtlSideBit] & ~useMini;
  assign miniSide  = ctlReg[CtlSideBit] & useMini;
  assign fdcReady  = useMini | driveReady;
  assign fdcSepClk = useMini | driveSepClk;

  always_comb begin
    ioRdData = '0;
    if (strobe.rdSel)
      ioRdData = {fdcDrq, fdcIntrq, fdcHld, 4'b0000, strobe.headSettled};
  end
endmodule

// File: rtl/floppy_glue.sv
module floppy_glue
  import floppy_glue_pkg::*;
#(
  parameter logic [7:0] PORT_ADDR   = 8'h34,
  parameter int         STEP_CYCLES = 64,
  parameter int         SETTLE_UNIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ioAddr,
  input  logic [7:0] ioWrData,
  input  logic       ioWrEn,
  input  logic       ioRdEn,
  output logic [7:0] ioRdData,
  input  logic       fdcStep,
  input  logic       fdcHld,
  input  logic       fdcDrq,
  input  logic       fdcIntrq,
  input  logic       driveReady,
  input  logic       driveSepClk,
  output logic       fdcReady,
  output logic       fdcSepClk,
  output logic [3:0] maxiSel,
  output logic       maxiStep,
  output logic       maxiSide,
  output logic [3:0] miniSel,
  output logic       miniStep,
  output logic       miniSide
);
  glueStrobe_t strobe;
  logic [1:0]  settlePreset;

  floppy_glue_ctrl #(
    .PORT_ADDR(PORT_ADDR), .STEP_CYCLES(STEP_CYCLES), .SETTLE_UNIT(SETTLE_UNIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .fdcStep(fdcStep), .fdcHld(fdcHld), .settlePreset(settlePreset), .strobe(strobe)
  );

  floppy_glue_datapath #(.NUM_DRIVES(4)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioWrData(ioWrData),
    .fdcHld(fdcHld), .fdcDrq(fdcDrq), .fdcIntrq(fdcIntrq),
    .driveReady(driveReady), .driveSepClk(driveSepClk),
    .settlePreset(settlePreset), .ioRdData(ioRdData),
    .fdcReady(fdcReady), .fdcSepClk(fdcSepClk),
    .maxiSel(maxiSel), .maxiStep(maxiStep), .maxiSide(maxiSide),
    .miniSel(miniSel), .miniStep(miniStep), .miniSide(miniSide)
  );
endmodule

// File: rtl/floppy_glue_checker.sv
module floppy_glue_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ioRdEn,
  input logic [7:0] ioRdData,
  input logic       fdcStep,
  input logic       fdcHld,
  input logic       fdcReady,
  input logic       fdcSepClk,
  input logic [3:0] maxiSel,
  input logic       maxiStep,
  input logic       maxiSide,
  input logic [3:0] miniSel,
  input logic       miniStep,
  input logic       miniSide
);
  a_r3_sel_needs_hld: assert property (@(posedge clk) disable iff (!rstN)
    (|{maxiSel, miniSel}) |-> fdcHld);

  a_r4_one_connector: assert property (@(posedge clk) disable iff (!rstN)
    !((|maxiSel || maxiStep || maxiSide) && (|miniSel || miniStep || miniSide)));

  a_r5_step_starts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fdcStep) |=> (maxiStep || miniStep));

  a_r7_mini_forces_high: assert property (@(posedge clk) disable iff (!rstN)
    (|miniSel || miniStep || miniSide) |-> (fdcReady && fdcSepClk));

  a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ioRdEn |-> (ioRdData == 8'h00));

  a_r9_settled_needs_hld: assert property (@(posedge clk) disable iff (!rstN)
    ioRdData[0] |-> fdcHld);
endmodule

bind floppy_glue floppy_glue_checker u_chk (
  .clk(clk), .rstN(rstN), .ioRdEn(ioRdEn), .ioRdData(ioRdData),
  .fdcStep(fdcStep), .fdcHld(fdcHld), .fdcReady(fdcReady), .fdcSepClk(fdcSepClk),
  .maxiSel(maxiSel), .maxiStep(maxiStep), .maxiSide(maxiSide),
  .miniSel(miniSel), .miniStep(miniStep), .miniSide(miniSide)
);

// File: tb/tb_floppy_glue.sv
module tb_floppy_glue;
  localparam int ClkPeriod = 10;
  localparam int StepCyc   = 64;
  localparam int Unit      = 16;

  logic clk = 0, rstN = 0;
  logic [7:0] ioAddr = 0, ioWrData = 0, ioRdData;
  logic ioWrEn = 0, ioRdEn = 0;
  logic fdcStep = 0, fdcHld = 0, fdcDrq = 0, fdcIntrq = 0;
  logic driveReady = 0, driveSepClk = 0, fdcReady, fdcSepClk;
  logic [3:0] maxiSel, miniSel;
  logic maxiStep, maxiSide, miniStep, miniSide;

  int checks = 0, errors = 0;
  logic [7:0] model = 0;
  bit done = 0;

  floppy_glue dut (.*);

  always #(ClkPeriod/2) clk = ~clk;

  initial begin
    #(ClkPeriod * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual not done, expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] expOuts(input logic [7:0] c, input logic hld,
                                          input logic rdy, input logic sck);
    logic m = c[4];
    logic [3:0] s = c[3:0] & {4{hld}};
    return {m ? 4'h0 : s, m ? 1'b0 : c[5], m ? s : 4'h0, m ? c[5] : 1'b0,
            m | rdy, m | sck, 6'b0};
  endfunction

  function automatic logic [17:0] actOuts();
    return {maxiSel, maxiSide, miniSel, miniSide, fdcReady, fdcSepClk, 6'b0};
  endfunction

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    ioAddr = a; ioWrData = d; ioWrEn = 1;
    cyc();
    ioWrEn = 0;
    if (a == 8'h34) model = d;
  endtask

  task automatic stepWidth(input string req, input logic useMini, input int retrigAt);
    int highs = 0;
    fdcStep = 1;
    for (int i = 1; i <= StepCyc + retrigAt + 4; i++) begin
      cyc();
      if (i == 2) fdcStep = 0;
      if (retrigAt > 0 && i == retrigAt) fdcStep = 1;
      if (retrigAt > 0 && i == retrigAt + 1) fdcStep = 0;
      if ((useMini ? miniStep : maxiStep)) highs++;
      chk("R4", {31'b0, useMini ? maxiStep : miniStep}, 0);
    end
    chk(req, highs, (retrigAt > 0) ? retrigAt + StepCyc : StepCyc);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk); cyc(); cyc();
    rstN = 1;
    // R1: reset state
    fdcHld = 1; ioRdEn = 1; ioAddr = 8'h00;
    @(negedge clk);
    chk("R1", {maxiSel, miniSel, maxiStep, miniStep, maxiSide, miniSide}, 0);
    chk("R1", ioRdData, 0);
    // R2/R3/R10 directed write
    wr(8'h34, 8'h25);
    chk("R2", actOuts(), expOuts(model, fdcHld, driveReady, driveSepClk));
    chk("R10", maxiSide, 1);
    wr(8'h35, 8'h1F);
    chk("R2", actOuts(), expOuts(8'h25, fdcHld, driveReady, driveSepClk));
    fdcHld = 0; @(negedge clk);
    chk("R3", maxiSel, 0);
    // R7 mini forcing
    wr(8'h34, 8'h32); driveReady = 0; driveSepClk = 0; fdcHld = 1;
    @(negedge clk);
    chk("R7", {fdcReady, fdcSepClk}, 2'b11);
    chk("R4", {maxiSel, miniSel, miniSide}, {4'h0, 4'h2, 1'b1});
    // R5/R6 step width on both connectors
    stepWidth("R5", 1'b1, 0);
    wr(8'h34, 8'h01);
    stepWidth("R5", 1'b0, 0);
    stepWidth("R6", 1'b0, 20);
    // R9 settle for every preset
    for (int p = 0; p < 4; p++) begin
      fdcHld = 0;
      wr(8'h34, {p[1:0], 6'h01});
      ioAddr = 8'h34; ioRdEn = 1;
      chk("R9", ioRdData[0], 0);
      fdcHld = 1;
      for (int i = 1; i <= (p + 1) * Unit + 2; i++) begin
        cyc();
        if (i == (p + 1) * Unit - 1 || i == (p + 1) * Unit || i == (p + 1) * Unit + 2)
          chk("R9", ioRdData[0], (i >= (p + 1) * Unit));
      end
    end
    fdcHld = 0; @(negedge clk);
    chk("R9", ioRdData[0], 0);
    // Random mix: R2 R3 R4 R7 R8 R10
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      a = ($urandom % 3 == 0) ? 8'h34 : 8'($urandom);
      fdcHld = 1'($urandom); fdcDrq = 1'($urandom); fdcIntrq = 1'($urandom);
      driveReady = 1'($urandom); driveSepClk = 1'($urandom);
      if ($urandom % 2 == 0) wr(a, 8'($urandom) & 8'h3F);
      ioAddr = ($urandom % 2 == 0) ? 8'h34 : 8'($urandom);
      ioRdEn = 1'($urandom);
      @(negedge clk);
      chk("R3", actOuts(), expOuts(model, fdcHld, driveReady, driveSepClk));
      chk("R8", ioRdData, (ioRdEn && ioAddr == 8'h34) ?
          {fdcDrq, fdcIntrq, fdcHld, 5'b0} : 8'h00);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule